// File: doc/BRIEF.md
# Half-Integer Clock Divider Branch

This block is one clock branch of a clock controller. It picks one of several source clocks, passes it through a glitch-free gate, and divides it by a ratio of the form N + 1.5. A ratio of that kind cannot be built from rising edges alone. The divider therefore counts every rising and every falling edge of the gated source. Each output period spans 2N+3 source half-periods: the output is high for N+1 of them and low for N+2.

All settings live in one 32-bit control word, written from a register clock domain. The low half holds three fields:

- the source select;
- the divider code;
- a gate-off bit.

In masked mode the high half of a written word acts as a per-bit write enable for the low half. In full mode a write replaces every writable field. The select field can be made read-only. The stored word can always be read back, so software can work out the output rate from the code.

Settings cross into the source clock domain through synchronizers. A new code is picked up only when the divider's two-period frame restarts. A gate-off request is honoured at the same point, which leaves the output low. The select should only be changed while the gate is closed.

Top module: `hdiv_branch`

## Requirements
- R1: On reset the control word reads zero: source 0, code 0 and gate enabled. `clk_o` is low while reset is held.
- R2: With code N and the gate open, `clk_o` stays high for N+1 half-periods of the selected source and low for N+2. Code 0 gives a ratio of 1.5.
- R3: The all-ones code (15 for the default 4-bit field) gives 16 high and 17 low half-periods.
- R4: In masked mode, written bit k+16 enables an update of stored bit k. Bits whose enable is clear keep their value, and the enable bits are not stored.
- R5: In full mode, a write copies written bits [15:0] into every writable field and ignores bits [31:16].
- R6: With the select made read-only, the select field stays 0 whatever is written.
- R7: `rd_data_o` returns the stored word with the select at bit 0, the divider code at bits [7:4], the gate-off bit at bit 15, and all other bits zero.
- R8: Select value s makes the divider count edges of `src_clk_i[s]`.
- R9: With the gate-off bit set, `clk_o` goes low within one divider frame and stays low. Clearing the bit resumes division.
- R10: A code change takes effect only at a period boundary. Every high and low phase seen during the change has the length of either the old code or the new one.
- R11: Without a write strobe the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset, all domains |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data; bits [31:16] are the per-bit enables in masked mode |
| rd_data_o | output | 32 | Stored control word |
| src_clk_i | input | NUM_SRC | Source clocks |
| clk_o | output | 1 | Divided output clock |

## Verification
The assertions check, on every cycle:

- the register stays stable when there is no write, and on a masked write with an all-zero enable half;
- a read-only select never moves;
- the frame counter stays within its bound for the active code;
- a new code is adopted only on the edge where the counter restarts;
- the output is low whenever the gate has been closed for a full source cycle.

Some behaviour only the bench's scenarios can show. These are the actual high and low phase lengths counted in source half-periods for several codes and both sources, the absence of runt phases across a code change, and the effect of partial and zero write masks on the resulting output rate.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  localparam int unsigned CTRL_W = 32;
  localparam int unsigned FIELD_W = CTRL_W / 2;

  typedef enum logic {
    WR_FULL   = 1'b0,
    WR_MASKED = 1'b1
  } wr_mode_e;
endpackage

// File: rtl/hdiv_ctrl_reg.sv
module hdiv_ctrl_reg
  import hdiv_pkg::*;
#(
  parameter wr_mode_e    WR_MODE      = WR_MASKED,
  parameter bit          HAS_SEL      = 1'b1,
  parameter bit          SEL_RO       = 1'b0,
  parameter int unsigned SEL_W        = 1,
  parameter int unsigned SEL_LSB      = 0,
  parameter int unsigned DIV_W        = 4,
  parameter int unsigned DIV_LSB      = 4,
  parameter int unsigned GATE_OFF_BIT = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DIV_W-1:0]  code_o,
  output logic              gate_en_o
);
  localparam logic [FIELD_W-1:0] SEL_M  = (HAS_SEL && !SEL_RO) ?
                                          FIELD_W'(((1 << SEL_W) - 1) << SEL_LSB) : '0;
  localparam logic [FIELD_W-1:0] DIV_M  = FIELD_W'(((1 << DIV_W) - 1) << DIV_LSB);
  localparam logic [FIELD_W-1:0] GATE_M = FIELD_W'(1) << GATE_OFF_BIT;
  localparam logic [FIELD_W-1:0] WR_M   = SEL_M | DIV_M | GATE_M;

  logic [FIELD_W-1:0] ctrl_q, ctrl_d, bit_en;

  generate
    if (WR_MODE == WR_MASKED) begin : g_masked
      assign bit_en = wr_data_i[CTRL_W-1:FIELD_W] & WR_M;
    end else begin : g_full
      logic unused_hi;
      assign unused_hi = ^wr_data_i[CTRL_W-1:FIELD_W];
      assign bit_en    = WR_M;
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) ctrl_d = (ctrl_q & ~bit_en) | (wr_data_i[FIELD_W-1:0] & bit_en);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign rd_data_o = {{(CTRL_W-FIELD_W){1'b0}}, ctrl_q};
  assign sel_o     = ctrl_q[SEL_LSB +: SEL_W];
  assign code_o    = ctrl_q[DIV_LSB +: DIV_W];
  assign gate_en_o = ~ctrl_q[GATE_OFF_BIT];
endmodule

// File: rtl/hdiv_src_mux.sv
module hdiv_src_mux #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned SEL_W   = 1
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               clk_o
);
  generate
    if (NUM_SRC > 1) begin : g_mux
      always_comb begin
        clk_o = src_i[0];
        for (int i = 1; i < NUM_SRC; i++) begin
          if (sel_i == SEL_W'(i)) clk_o = src_i[i];
        end
      end
    end else begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign clk_o      = src_i[0];
    end
  endgenerate
endmodule

// File: rtl/hdiv_sync.sv
module hdiv_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hdiv_clk_gate.sv
module hdiv_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic stop_i,
  output logic open_o,
  output logic gclk_o
);
  logic en_q;

  // enable moves only while clk_i is low; it closes once the divider has parked
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= run_i | (en_q & ~stop_i);
  end

  assign open_o = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/hdiv_core.sv
module hdiv_core #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             gclk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             clk_o,
  output logic             stop_o,
  output logic [DIV_W-1:0] code_act_o,
  output logic [DIV_W+1:0] cnt_o
);
  localparam int unsigned CW = DIV_W + 2;
  localparam int unsigned HW = CW + 1;

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DIV_W-1:0] n_q, n_d;
  logic             stop_q, stop_d;
  logic             pos_q, neg_q, lvl_pos, lvl_neg, wrap;

  // level of the output during half-period h of a two-period frame
  function automatic logic lvl_at(input logic [HW-1:0] h, input logic [DIV_W-1:0] n);
    logic [HW-1:0] per, q;
    per = {2'b00, n, 1'b1} + HW'(2);
    q   = (h >= per) ? h - per : h;
    return q <= HW'(n);
  endfunction

  assign wrap = cnt_q >= ({1'b0, n_q, 1'b0} + CW'(2));

  always_comb begin
    cnt_d   = cnt_q;
    n_d     = n_q;
    stop_d  = stop_q;
    lvl_pos = 1'b0;
    if (stop_q) begin
      if (run_i) begin
        stop_d  = 1'b0;
        cnt_d   = '0;
        n_d     = code_i;
        lvl_pos = 1'b1;
      end
    end else if (wrap) begin
      if (!run_i) begin
        stop_d = 1'b1;
        cnt_d  = '1;
      end else begin
        cnt_d   = '0;
        n_d     = code_i;
        lvl_pos = 1'b1;
      end
    end else begin
      cnt_d   = cnt_q + CW'(1);
      lvl_pos = lvl_at({cnt_d, 1'b0}, n_q);
    end
  end

  assign lvl_neg = ~stop_q & lvl_at({cnt_q, 1'b1}, n_q);

  always_ff @(posedge gclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      n_q    <= '0;
      stop_q <= 1'b1;
      pos_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      n_q    <= n_d;
      stop_q <= stop_d;
      pos_q  <= lvl_pos ^ neg_q;
    end
  end

  always_ff @(negedge gclk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= lvl_neg ^ pos_q;
  end

  // each edge flop flips only when its edge must move the output
  assign clk_o      = pos_q ^ neg_q;
  assign stop_o     = stop_q;
  assign code_act_o = n_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/hdiv_branch.sv
module hdiv_branch
  import hdiv_pkg::*;
#(
  parameter int unsigned NUM_SRC      = 2,
  parameter wr_mode_e    WR_MODE      = WR_MASKED,
  parameter bit          SEL_RO       = 1'b0,
  parameter int unsigned SEL_LSB      = 0,
  parameter int unsigned DIV_W        = 4,
  parameter int unsigned DIV_LSB      = 4,
  parameter int unsigned GATE_OFF_BIT = 15,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [31:0]        wr_data_i,
  output logic [31:0]        rd_data_o,
  input  logic [NUM_SRC-1:0] src_clk_i,
  output logic               clk_o
);
  localparam int unsigned SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam bit          HAS_SEL = NUM_SRC > 1;

  logic [SEL_W-1:0] sel;
  logic [DIV_W-1:0] code, code_s, code_act;
  logic [DIV_W+1:0] cnt;
  logic             gate_en, run_s, mclk, gclk, stop, gate_open;

  hdiv_ctrl_reg #(
    .WR_MODE(WR_MODE), .HAS_SEL(HAS_SEL), .SEL_RO(SEL_RO), .SEL_W(SEL_W),
    .SEL_LSB(SEL_LSB), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB), .GATE_OFF_BIT(GATE_OFF_BIT)
  ) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .sel_o(sel), .code_o(code), .gate_en_o(gate_en)
  );

  hdiv_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) i_mux (
    .src_i(src_clk_i), .sel_i(sel), .clk_o(mclk)
  );

  hdiv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_run_sync (
    .clk_i(mclk), .rst_ni(rst_ni), .d_i(gate_en), .q_o(run_s)
  );

  // code is quasi-static: sampled by the divider only at frame restart
  hdiv_sync #(.WIDTH(DIV_W), .STAGES(SYNC_STAGES)) i_code_sync (
    .clk_i(mclk), .rst_ni(rst_ni), .d_i(code), .q_o(code_s)
  );

  hdiv_clk_gate i_gate (
    .clk_i(mclk), .rst_ni(rst_ni), .run_i(run_s), .stop_i(stop),
    .open_o(gate_open), .gclk_o(gclk)
  );

  hdiv_core #(.DIV_W(DIV_W)) i_core (
    .gclk_i(gclk), .rst_ni(rst_ni), .run_i(run_s), .code_i(code_s),
    .clk_o(clk_o), .stop_o(stop), .code_act_o(code_act), .cnt_o(cnt)
  );
endmodule

// File: rtl/hdiv_branch_chk.sv
module hdiv_branch_chk
  import hdiv_pkg::*;
#(
  parameter wr_mode_e    WR_MODE = WR_MASKED,
  parameter bit          SEL_RO  = 1'b0,
  parameter int unsigned SEL_W   = 1,
  parameter int unsigned SEL_LSB = 0,
  parameter int unsigned DIV_W   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [15:0]      wr_mask,
  input logic [31:0]      rd_data_o,
  input logic             mclk,
  input logic             gclk,
  input logic             gate_open,
  input logic             clk_o,
  input logic             stop,
  input logic [DIV_W+1:0] cnt,
  input logic [DIV_W-1:0] code_act
);
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));

  generate
    if (WR_MODE == WR_MASKED) begin : g_mask_chk
      // R4
      zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_mask == 16'h0) |=> $stable(rd_data_o));
    end
    if (SEL_RO) begin : g_ro_chk
      // R6
      sel_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> $stable(rd_data_o[SEL_LSB +: SEL_W]));
    end
  endgenerate

  // R9
  gated_low_chk: assert property (@(posedge mclk) disable iff (!rst_ni)
    (!gate_open && $past(!gate_open)) |-> !clk_o);

  // R10
  code_at_boundary_chk: assert property (@(posedge gclk) disable iff (!rst_ni)
    !$stable(code_act) |-> cnt == '0);

  // R2
  cnt_range_chk: assert property (@(posedge gclk) disable iff (!rst_ni)
    !stop |-> cnt <= ({1'b0, code_act, 1'b0} + (DIV_W+2)'(2)));
endmodule

bind hdiv_branch hdiv_branch_chk #(
  .WR_MODE(WR_MODE), .SEL_RO(SEL_RO), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB), .DIV_W(DIV_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_mask(wr_data_i[31:16]),
  .rd_data_o(rd_data_o), .mclk(mclk), .gclk(gclk), .gate_open(gate_open),
  .clk_o(clk_o), .stop(stop), .cnt(cnt), .code_act(code_act)
);

// File: tb/test_hdiv_branch.sv
module test_hdiv_branch;
  import hdiv_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SRC0_HALF  = 7;
  localparam int SRC1_HALF  = 11;
  localparam logic [15:0] WM_MAIN = 16'h80F1;
  localparam logic [15:0] WM_ALT  = 16'h80F0;

  logic        clk, rst_n, wr_en, clk_o, clk_o_alt;
  logic [31:0] wr_data, rd, rd_alt;
  logic [1:0]  src;
  logic [15:0] model, model_alt;
  int          checks, fails, rises;
  bit          done;

  hdiv_branch i_hdiv_branch (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd), .src_clk_i(src), .clk_o(clk_o)
  );

  hdiv_branch #(.WR_MODE(WR_FULL), .SEL_RO(1'b1)) i_hdiv_branch_alt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_alt), .src_clk_i(src), .clk_o(clk_o_alt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  initial src = 2'b00;
  always #(SRC0_HALF) src[0] = ~src[0];
  always #(SRC1_HALF) src[1] = ~src[1];

  always @(posedge clk_o) rises++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [15:0] apply_wr(input logic [15:0] cur, input logic [31:0] d,
                                           input bit masked, input logic [15:0] wm);
    logic [15:0] r = cur;
    for (int k = 0; k < 16; k++)
      if (wm[k] && (!masked || d[k+16])) r[k] = d[k];
    return r;
  endfunction

  // register reference compared on every clock (R7, R11, R4, R5, R6)
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(rd == {16'h0, model}, "R7 main readback", int'(rd), int'({16'h0, model}));
      chk(rd_alt == {16'h0, model_alt}, "R5 alt readback", int'(rd_alt), int'({16'h0, model_alt}));
    end
  end

  task automatic write(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    model     = apply_wr(model, d, 1'b1, WM_MAIN);
    model_alt = apply_wr(model_alt, d, 1'b0, WM_ALT);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic src_edge();
    if (model[0]) @(src[1]);
    else          @(src[0]);
  endtask

  task automatic settle();
    repeat (6) @(posedge clk_o);
  endtask

  // phase lengths counted in half-periods of the selected source
  task automatic measure(input int n_a, input int n_b, input int periods, input string req);
    int hi, lo;
    @(posedge clk_o);
    #1;
    hi = 1;
    for (int p = 0; p < periods; p++) begin
      forever begin src_edge(); #1; if (clk_o) hi++; else break; end
      chk(hi == n_a + 1 || hi == n_b + 1, req, hi, n_b + 1);
      lo = 1;
      forever begin src_edge(); #1; if (!clk_o) lo++; else break; end
      chk(lo == n_a + 2 || lo == n_b + 2, req, lo, n_b + 2);
      hi = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int r0;
    checks = 0; fails = 0; rises = 0; done = 1'b0;
    model = '0; model_alt = '0;
    wr_en = 1'b0; wr_data = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #2;
    chk(rd == 32'h0, "R1 reset word", int'(rd), 0);
    chk(rd_alt == 32'h0, "R1 reset word alt", int'(rd_alt), 0);
    chk(clk_o == 1'b0, "R1 output low in reset", int'(clk_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    settle();
    measure(0, 0, 4, "R2 ratio 1.5 after reset");

    write(32'h00F0_0030);
    settle();
    measure(3, 3, 4, "R2 code 3");

    write(32'h0000_0050);
    chk(rd_alt[7:4] == 4'd5, "R5 full write", int'(rd_alt[7:4]), 5);
    chk(rd[7:4] == 4'd3, "R4 zero mask", int'(rd[7:4]), 3);
    settle();
    measure(3, 3, 3, "R4 zero mask keeps rate");

    write(32'h0010_00E0);
    chk(rd[7:4] == 4'd2, "R4 partial mask", int'(rd[7:4]), 2);
    settle();
    measure(2, 2, 3, "R4 partial mask rate");

    write(32'h00F0_00F0);
    settle();
    measure(15, 15, 2, "R3 largest code");

    fork
      write(32'h00F0_0010);
    join_none
    measure(15, 1, 8, "R10 no runt on change");
    settle();
    measure(1, 1, 3, "R10 new code");

    write(32'h8000_8000);
    repeat (200) @(posedge clk);
    r0 = rises;
    repeat (200) @(posedge clk);
    #2;
    chk(rises == r0, "R9 gated no edges", rises - r0, 0);
    chk(clk_o == 1'b0, "R9 gated low", int'(clk_o), 0);

    write(32'h0001_0001);
    chk(rd[0] == 1'b1, "R8 select written", int'(rd[0]), 1);
    chk(rd_alt[0] == 1'b0, "R6 read-only select", int'(rd_alt[0]), 0);
    write(32'h8000_0000);
    settle();
    measure(1, 1, 4, "R8 source 1 code 1");

    write(32'h00F0_0060);
    #2;
    chk(rd == 32'h0000_0061, "R7 field layout", int'(rd), 32'h61);
    settle();
    measure(6, 6, 3, "R8 source 1 code 6");

    finish_run();
  end
endmodule